// File: doc/BRIEF.md
# Audio clock ratio generator

This block runs on the root audio clock and produces the timing for a serial audio link. It gives a one-cycle bit-clock enable, a one-cycle frame-start pulse and a left/right channel indicator, which a serializer uses to shift out samples. The root clock runs at a fixed multiple of the sample rate. That multiple is selected by a request code. The bit rate is a second selectable multiple of the sample rate.

The block divides the root clock by (root ratio / bit ratio) to get the bit-clock enable. Some combinations do not divide to a whole number, such as 256 with 24. If the block is enabled with such a combination, it raises a sticky configuration error and keeps every timing output idle. A new request code, and a change of the enable, is taken only at a frame boundary, so the block never produces a partial frame.

A separate input states whether the root clock comes from outside. From it the block derives the output enable for driving the root clock out to a codec.

Top module: `audclk_ratio_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it, `bclk_en`, `frame_start`, `ws_right` and `cfg_err` are 0. The active setting after reset is root 256, bit 16.
- R2: `root_sel` codes map as 0→256, 1→384, 2→512, 3→768 root cycles per frame. Codes 4 to 7 select 256.
- R3: `bclk_sel` codes map as 0→16, 1→24, 2→32, 3→48 bit clocks per frame. Codes 4 to 7 leave the active bit ratio unchanged.
- R4: Within a frame of R root cycles and B bits, with D = R/B, `bclk_en` is high for exactly one cycle at frame cycle offsets D-1, 2D-1, … , R-1 and low at all other offsets.
- R5: `frame_start` is high only at frame cycle offset 0. `ws_right` is 0 (left channel) for offsets 0 to R/2-1 and 1 (right channel) for offsets R/2 to R-1.
- R6: While running, requests and the enable are sampled only at the last cycle of a frame. The next frame follows immediately with no gap. While idle, a request takes effect on the next clock edge.
- R7: If the block is enabled with a combination where R is not a multiple of B (256 or 512 with 24 or 48), it sets `cfg_err` and holds `bclk_en`, `frame_start` and `ws_right` at 0. `cfg_err` stays set until reset, even after a valid setting restarts the frames.
- R8: If the enable is low at a frame boundary, the block finishes that frame and then stays idle. An invalid combination requested while the enable is low does not set `cfg_err`.
- R9: `root_clk_oe` is the inverse of `ext_root`. When the root clock is supplied from outside it is not driven out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run request, sampled at frame boundaries |
| root_sel | input | 3 | Root-to-sample ratio request code |
| bclk_sel | input | 3 | Bit-to-sample ratio request code |
| ext_root | input | 1 | 1 when the root clock is supplied from outside |
| root_clk_oe | output | 1 | Output enable for driving the root clock to the codec |
| bclk_en | output | 1 | One-cycle bit-clock enable |
| frame_start | output | 1 | One-cycle pulse on the first cycle of a frame |
| ws_right | output | 1 | Channel indicator, 1 during the right half-frame |
| cfg_err | output | 1 | Sticky non-integer ratio error |

## Verification
The hardest case to reach from the ports is a request that changes in the middle of a running frame. The only evidence that it was held back is the shape of the frame in progress. The bench therefore writes each new request one cycle after a frame start. The scoreboard then expects the old ratio for the rest of that frame and the new one, with no gap, for the next frame. The error path is reached in two ways: from idle, and by queuing an invalid combination for the boundary of a running frame. A later reset, with the enable low, shows the flag clears and that an invalid request alone does not set it again.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int SEL_W   = 3;
  localparam int CODE_W  = 2;
  localparam int RATIO_W = 10;

  typedef logic [CODE_W-1:0] code_t;

  // Root request: unknown codes fall back to code 0 (256).
  function automatic code_t root_norm(input logic [SEL_W-1:0] req);
    if (req[SEL_W-1:CODE_W] == '0) return req[CODE_W-1:0];
    return '0;
  endfunction

  function automatic logic bit_req_known(input logic [SEL_W-1:0] req);
    return req[SEL_W-1:CODE_W] == '0;
  endfunction

  function automatic logic [RATIO_W-1:0] root_ratio(input code_t c);
    case (c)
      2'd0:    return 10'd256;
      2'd1:    return 10'd384;
      2'd2:    return 10'd512;
      default: return 10'd768;
    endcase
  endfunction

  function automatic logic [RATIO_W-1:0] bit_ratio(input code_t c);
    case (c)
      2'd0:    return 10'd16;
      2'd1:    return 10'd24;
      2'd2:    return 10'd32;
      default: return 10'd48;
    endcase
  endfunction

  // Power-of-two roots (even codes) cannot be split into 3*2^n bits (odd codes).
  function automatic logic combo_ok(input code_t rc, input code_t bc);
    return !(!rc[0] && bc[0]);
  endfunction

  // Root cycles per bit clock; 0 marks a non-integer pair.
  function automatic logic [RATIO_W-1:0] root_per_bit(input code_t rc, input code_t bc);
    case ({rc, bc})
      4'b00_00: return 10'd16;
      4'b00_10: return 10'd8;
      4'b01_00: return 10'd24;
      4'b01_01: return 10'd16;
      4'b01_10: return 10'd12;
      4'b01_11: return 10'd8;
      4'b10_00: return 10'd32;
      4'b10_10: return 10'd16;
      4'b11_00: return 10'd48;
      4'b11_01: return 10'd32;
      4'b11_10: return 10'd24;
      4'b11_11: return 10'd16;
      default:  return 10'd0;
    endcase
  endfunction
endpackage

// File: rtl/audclk_ratio_sel.sv
module audclk_ratio_sel
  import audclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] root_req,
  input  logic [SEL_W-1:0] bit_req,
  output code_t            root_code,
  output code_t            bit_code,
  output logic             next_ok
);
  code_t root_nxt;
  code_t bit_nxt;

  always_comb begin
    root_nxt = root_norm(root_req);
    bit_nxt  = bit_req_known(bit_req) ? bit_req[CODE_W-1:0] : bit_code;
    next_ok  = combo_ok(root_nxt, bit_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_code <= '0;
      bit_code  <= '0;
    end else if (load) begin
      root_code <= root_nxt;
      bit_code  <= bit_nxt;
    end
  end
endmodule

// File: rtl/audclk_frame_ctr.sv
module audclk_frame_ctr #(
  parameter int DIV_W  = 6,
  parameter int BCNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [BCNT_W-1:0] bits,
  output logic              bclk_en,
  output logic              frame_start,
  output logic              frame_last,
  output logic              ws
);
  logic [DIV_W-1:0]  div_cnt;
  logic [BCNT_W-1:0] bit_cnt;
  logic              div_last;
  logic              bit_last;

  assign div_last = div_cnt == div - DIV_W'(1);
  assign bit_last = bit_cnt == bits - BCNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      div_cnt <= '0;
      bit_cnt <= '0;
    end else if (run) begin
      div_cnt <= div_last ? '0 : div_cnt + DIV_W'(1);
      if (div_last) bit_cnt <= bit_last ? '0 : bit_cnt + BCNT_W'(1);
    end
  end

  assign bclk_en     = run && div_last;
  assign frame_last  = run && div_last && bit_last;
  assign frame_start = run && (div_cnt == '0) && (bit_cnt == '0);
  assign ws          = run && (bit_cnt >= (bits >> 1));
endmodule

// File: rtl/audclk_ratio_gen.sv
module audclk_ratio_gen
  import audclk_pkg::*;
#(
  parameter int MAX_DIV = 48,
  parameter int MAX_BIT = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] root_sel,
  input  logic [SEL_W-1:0] bclk_sel,
  input  logic             ext_root,
  output logic             root_clk_oe,
  output logic             bclk_en,
  output logic             frame_start,
  output logic             ws_right,
  output logic             cfg_err
);
  localparam int DIV_W  = $clog2(MAX_DIV + 1);
  localparam int BCNT_W = $clog2(MAX_BIT + 1);

  code_t             act_root;
  code_t             act_bit;
  logic              next_ok;
  logic              running;
  logic              frame_last;
  logic              load_evt;
  logic [DIV_W-1:0]  div_w;
  logic [BCNT_W-1:0] bits_w;

  // Settings are taken whenever idle, or on the last cycle of a frame.
  assign load_evt = !running || frame_last;

  audclk_ratio_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .root_req  (root_sel),
    .bit_req   (bclk_sel),
    .root_code (act_root),
    .bit_code  (act_bit),
    .next_ok   (next_ok)
  );

  assign div_w  = DIV_W'(root_per_bit(act_root, act_bit));
  assign bits_w = BCNT_W'(bit_ratio(act_bit));

  audclk_frame_ctr #(.DIV_W(DIV_W), .BCNT_W(BCNT_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load_evt),
    .run         (running),
    .div         (div_w),
    .bits        (bits_w),
    .bclk_en     (bclk_en),
    .frame_start (frame_start),
    .frame_last  (frame_last),
    .ws          (ws_right)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cfg_err <= 1'b0;
    end else if (load_evt) begin
      running <= en && next_ok;
      if (en && !next_ok) cfg_err <= 1'b1;
    end
  end

  assign root_clk_oe = !ext_root;
endmodule

// File: rtl/audclk_ratio_gen_chk.sv
module audclk_ratio_gen_chk
  import audclk_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  en,
  input logic  running,
  input logic  frame_last,
  input code_t act_root,
  input code_t act_bit,
  input logic  bclk_en,
  input logic  frame_start,
  input logic  ws_right,
  input logic  cfg_err
);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R8
  err_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(en));

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !frame_last) |=> ($stable(act_root) && $stable(act_bit)));

  // R6
  start_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($past(frame_last) || !$past(running)));

  // R5
  start_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !ws_right);

  // R4
  ws_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ws_right) |-> $past(bclk_en));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!bclk_en && !frame_start && !ws_right));
endmodule

bind audclk_ratio_gen audclk_ratio_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .running     (running),
  .frame_last  (frame_last),
  .act_root    (act_root),
  .act_bit     (act_bit),
  .bclk_en     (bclk_en),
  .frame_start (frame_start),
  .ws_right    (ws_right),
  .cfg_err     (cfg_err)
);

// File: tb/audclk_ratio_gen_tb.sv
module audclk_ratio_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ext_root = 1'b0;
  logic [2:0] root_sel = 3'd0;
  logic [2:0] bclk_sel = 3'd0;
  wire        root_clk_oe, bclk_en, frame_start, ws_right, cfg_err;

  always #10 clk = ~clk;

  audclk_ratio_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .root_sel(root_sel), .bclk_sel(bclk_sel),
    .ext_root(ext_root), .root_clk_oe(root_clk_oe), .bclk_en(bclk_en),
    .frame_start(frame_start), .ws_right(ws_right), .cfg_err(cfg_err)
  );

  typedef struct { int r; int b; } frm_t;
  frm_t q[$];
  frm_t cur;
  int   checks = 0, fails = 0, cyc = 0, t = 0, mism = 0, idle_bad = 0;
  int   bad_t = 0, bad_bclk = 0, bad_ws = 0;
  bit   in_frame = 0, expect_next = 0, done = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor / scoreboard: one expected frame popped per frame start.
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      in_frame = 0;
      expect_next = 0;
    end else begin
      if (in_frame) begin
        t++;
        if (t == cur.r) in_frame = 0;
      end
      if (expect_next) begin
        expect_next = 0;
        check("R6 back-to-back frame start", int'(frame_start), 1);
      end
      if (frame_start) begin
        if (in_frame) begin
          check("R5 early frame start offset", t, cur.r);
        end else if (q.size() == 0) begin
          check("R7/R8 unexpected frame start", 1, 0);
        end else begin
          cur = q.pop_front();
          in_frame = 1; t = 0; mism = 0;
        end
      end
      if (in_frame) begin
        int  d;
        bit  eb, ew;
        d  = cur.r / cur.b;
        eb = (t % d) == d - 1;
        ew = t >= cur.r / 2;
        if (bclk_en !== eb || ws_right !== ew) begin
          if (mism == 0) begin bad_t = t; bad_bclk = int'(bclk_en); bad_ws = int'(ws_right); end
          mism++;
        end
        if (t == cur.r - 1) begin
          checks++;
          if (mism != 0) begin
            fails++;
            $display("FAIL R2/R3/R4/R5 frame %0d/%0d: offset %0d actual bclk=%0d ws=%0d expected bclk=%0d ws=%0d",
                     cur.r, cur.b, bad_t, bad_bclk, bad_ws,
                     int'((bad_t % d) == d - 1), int'(bad_t >= cur.r / 2));
          end
          if (q.size() > 0) expect_next = 1;
        end
      end else if (bclk_en !== 1'b0 || ws_right !== 1'b0 || frame_start !== 1'b0) begin
        idle_bad++;
      end
    end
  end

  task automatic check_idle(input string req);
    check(req, idle_bad, 0);
    idle_bad = 0;
  endtask

  task automatic wait_start();
    do @(negedge clk); while (frame_start !== 1'b1);
  endtask

  // Driver: called mid-frame, the request applies to the following frame.
  task automatic next_frame(input logic [2:0] rs, input logic [2:0] bs, input int er, input int eb);
    wait_start();
    root_sel = rs;
    bclk_sel = bs;
    q.push_back('{er, eb});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bclk_en in reset", int'(bclk_en), 0);
    check("R1 cfg_err in reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 frame_start after reset", int'(frame_start), 0);
    check("R1 ws_right after reset", int'(ws_right), 0);

    // R9 root clock direction
    ext_root = 1'b0; #1;
    check("R9 root_clk_oe driven out", int'(root_clk_oe), 1);
    ext_root = 1'b1; #1;
    check("R9 root_clk_oe external", int'(root_clk_oe), 0);

    // R2 R3 R4 R5 R6: sweep of settings, each changed mid-frame
    root_sel = 3'd0; bclk_sel = 3'd2;
    q.push_back('{256, 32});
    en = 1'b1;
    next_frame(3'd1, 3'd1, 384, 24);
    next_frame(3'd1, 3'd0, 384, 16);
    next_frame(3'd3, 3'd3, 768, 48);
    next_frame(3'd2, 3'd2, 512, 32);
    next_frame(3'd6, 3'd0, 256, 16);   // R2 unknown root code
    next_frame(3'd3, 3'd5, 768, 16);   // R3 unknown bit code keeps 16
    next_frame(3'd1, 3'd3, 384, 48);
    next_frame(3'd1, 3'd7, 384, 48);   // R3 keeps 48

    // R8 stop at frame end
    wait_start();
    en = 1'b0;
    repeat (800) @(negedge clk);
    check_idle("R8 idle after disable");
    check("R6 all queued frames seen", q.size(), 0);
    check("R7 no error on valid settings", int'(cfg_err), 0);

    // R7 invalid combination from idle
    root_sel = 3'd0; bclk_sel = 3'd1;
    en = 1'b1;
    repeat (20) @(negedge clk);
    check("R7 cfg_err on 256/24", int'(cfg_err), 1);
    bclk_sel = 3'd3;
    repeat (20) @(negedge clk);
    check_idle("R7 idle on 256/24 and 256/48");

    // R7 recovery keeps the flag
    q.push_back('{384, 24});
    root_sel = 3'd1; bclk_sel = 3'd1;
    wait_start();
    check("R7 cfg_err sticky after recovery", int'(cfg_err), 1);
    root_sel = 3'd2; bclk_sel = 3'd1;    // 512/24 queued for the boundary
    repeat (450) @(negedge clk);
    check_idle("R7 idle after invalid boundary load");
    check("R6 frames consumed", q.size(), 0);

    // R1 reset clears, R8 no error while disabled
    en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 cfg_err cleared by reset", int'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R8 invalid request while disabled", int'(cfg_err), 0);
    check_idle("R8 idle while disabled");

    summary();
  end
endmodule